// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the line and frame timing for a raster display: horizontal and vertical sync, a border-active window, a display-active window nested inside it and a hardware cursor window. All timing comes from a set of registers loaded through one 32-bit tagged write word. The top six bits of the word pick the register, and the value sits in a field lower down. The horizontal counter steps once per clock, and each clock stands for one pair of pixels. The vertical counter steps once per line.

Each axis is tracked by a small segment state machine whose states are `SEG_SYNC`, `SEG_LEAD_BLANK`, `SEG_LEAD_BORDER`, `SEG_ACTIVE`, `SEG_TRAIL_BORDER` and `SEG_TRAIL_BLANK`. On every step the machine reclassifies the next count against the programmed boundaries. The transitions are sync-to-lead-blank at sync width + 1, lead-blank-to-lead-border at border start + 1, lead-border-to-active at display start + 1, active-to-trail-border at display end + 1, trail-border-to-trail-blank at border end + 1, and any state back to sync when the counter wraps. The horizontal machine steps every clock. The vertical machine steps on the last count of each line.

Writes land in a pending copy and reach the working copy only at the frame boundary, so a frame never changes its geometry part way through. A control word selects interlace, composite sync and a two-bit dot clock code. With interlace on, vertical sync on odd fields is shifted along the line by a programmed horizontal amount.

Top module: `raster_timing_gen`

## Requirements
- R1: A write with `wr_en` high sets the register named by `wr_data[31:26]`: 0x20..0x27 horizontal (cycle, sync width, border start, display start, display end, border end, cursor start, interlace shift), 0x28..0x2F vertical (cycle, sync width, border start, display start, display end, border end, cursor start, cursor end), and 0x38 control. Timing values are `wr_data[14 +: VAL_W]`. Any other tag, or `wr_en` low, changes nothing.
- R2: The horizontal count runs 0..hcycle+1 and advances one step per clock. At the wrap the vertical count advances, running 0..vcycle.
- R3: `hsync` is high while hcount < hsync_width+1. On even or non-interlaced fields `vsync` is high while vcount < vsync_width+1.
- R4: `border_active` is high when hcount is in [hborder_start+1, hborder_end+1) and vcount is in [vborder_start+1, vborder_end+1).
- R5: `display_active` is high when hcount is in [hdisplay_start+1, hdisplay_end+1) and vcount is in [vdisplay_start+1, vdisplay_end+1). It is never high without `border_active`.
- R6: `cursor_window` is high when 2*hcount is in [hcursor, hcursor+CURSOR_PIX) and vcount is in [vcursor_start+1, vcursor_end+1). The horizontal cursor value is in pixels. At write time it is taken from `wr_data[13 +: VAL_W+1]`, or from `wr_data[11 +: VAL_W+3]` when `hires_cursor` is high.
- R7: Control bit 7 = 1 makes `sync_out` equal `hsync ^ vsync`. Otherwise `sync_out` equals `hsync`.
- R8: Control bit 6 = 1 makes `field_odd` toggle at each frame boundary. Control bit 6 = 0 clears it there. On an odd field `vsync` rises at hcount = hshift on line 0 and falls at hcount = hshift on line vsync_width+1.
- R9: Every write, control included, takes effect at the next frame boundary and not before.
- R10: `dot_sel` equals control bits [1:0] (00 = 8, 01 = 12, 10 = 16, 11 = 24 MHz).
- R11: Reset clears both counts, `field_odd` and all registers. While reset is held, and on leaving it, `hsync` = `vsync` = `sync_out` = 1 and the other outputs are 0. Lines are then two counts long and frames one line long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one pixel pair per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Tagged write word |
| hires_cursor | input | 1 | Chooses the high-resolution cursor field position |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| sync_out | output | 1 | Composite or horizontal sync per control |
| border_active | output | 1 | Inside the border window |
| display_active | output | 1 | Inside the display window |
| cursor_window | output | 1 | Inside the cursor window |
| field_odd | output | 1 | Current field is odd |
| dot_sel | output | 2 | Dot clock select code |

## Verification
The bench follows its own count model through whole frames for three geometries. Every window edge therefore lands at the counts the requirements name, and an off-by-one at any start or end shows up as a mismatch at that exact count. Writes are issued in the middle of a frame to check that the current frame keeps its old geometry, so a design that applies writes at once would change the line length early. Interlaced frames check the shifted odd-field vertical sync at both its start and end lines. Writes with unknown tags or without the strobe are shown to leave every output unchanged, and the high-resolution cursor field position is exercised as well.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    localparam int TAG_W          = 6;
    localparam logic [5:0] TAG_H_BASE = 6'h20;
    localparam logic [5:0] TAG_V_BASE = 6'h28;
    localparam logic [5:0] TAG_CTRL   = 6'h38;

    localparam int NUM_AXIS_REGS  = 8;

    // horizontal slots
    localparam int IDX_CYCLE      = 0;
    localparam int IDX_SYNC_W     = 1;
    localparam int IDX_BORD_START = 2;
    localparam int IDX_DISP_START = 3;
    localparam int IDX_DISP_END   = 4;
    localparam int IDX_BORD_END   = 5;
    localparam int IDX_CUR_START  = 6;
    localparam int IDX_H_SHIFT    = 7;
    localparam int IDX_V_CUR_END  = 7;

    localparam int FIELD_LSB_TIMING = 14;
    localparam int FIELD_LSB_CURSOR = 13;
    localparam int FIELD_LSB_CUR_HI = 11;

    localparam int CTL_BIT_INTERLACE = 6;
    localparam int CTL_BIT_COMPOSITE = 7;

    typedef enum logic [2:0] {
        SEG_SYNC,
        SEG_LEAD_BLANK,
        SEG_LEAD_BORDER,
        SEG_ACTIVE,
        SEG_TRAIL_BORDER,
        SEG_TRAIL_BLANK
    } seg_e;

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
    import rtg_pkg::*;
#(
    parameter int VAL_W = 10,
    parameter int CUR_W = VAL_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic             hires_cursor,
    input  logic             frame_end,
    output logic [VAL_W-1:0] h_act [NUM_AXIS_REGS],
    output logic [VAL_W-1:0] v_act [NUM_AXIS_REGS],
    output logic [CUR_W-1:0] h_cur,
    output logic             ctl_il,
    output logic             ctl_cs,
    output logic [1:0]       ctl_dot
);

    localparam int CUR_LO_W = CUR_W - 2;

    logic [TAG_W-1:0] tag;
    logic [VAL_W-1:0] timing_val;
    logic [CUR_W-1:0] cursor_val;
    logic             unused_wr_parity;

    logic [VAL_W-1:0] h_pend [NUM_AXIS_REGS];
    logic [VAL_W-1:0] v_pend [NUM_AXIS_REGS];
    logic [CUR_W-1:0] cur_pend;
    logic             il_pend;
    logic             cs_pend;
    logic [1:0]       dot_pend;

    always_comb begin
        tag              = wr_data[31 -: TAG_W];
        timing_val       = wr_data[FIELD_LSB_TIMING +: VAL_W];
        unused_wr_parity = ^wr_data;
        if (hires_cursor) begin
            cursor_val = wr_data[FIELD_LSB_CUR_HI +: CUR_W];
        end else begin
            cursor_val = CUR_W'(wr_data[FIELD_LSB_CURSOR +: CUR_LO_W]);
        end
    end

    // pending copy: written by the port at any time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_AXIS_REGS; i++) begin
                h_pend[i] <= '0;
                v_pend[i] <= '0;
            end
            cur_pend <= '0;
            il_pend  <= 1'b0;
            cs_pend  <= 1'b0;
            dot_pend <= 2'b00;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_AXIS_REGS; i++) begin
                if (tag == TAG_H_BASE + TAG_W'(i)) begin
                    h_pend[i] <= timing_val;
                end
                if (tag == TAG_V_BASE + TAG_W'(i)) begin
                    v_pend[i] <= timing_val;
                end
            end
            if (tag == TAG_H_BASE + TAG_W'(IDX_CUR_START)) begin
                cur_pend <= cursor_val;
            end
            if (tag == TAG_CTRL) begin
                il_pend  <= wr_data[CTL_BIT_INTERLACE];
                cs_pend  <= wr_data[CTL_BIT_COMPOSITE];
                dot_pend <= wr_data[1:0];
            end
        end
    end

    // working copy: refreshed only at the frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_AXIS_REGS; i++) begin
                h_act[i] <= '0;
                v_act[i] <= '0;
            end
            h_cur   <= '0;
            ctl_il  <= 1'b0;
            ctl_cs  <= 1'b0;
            ctl_dot <= 2'b00;
        end else if (frame_end) begin
            for (int i = 0; i < NUM_AXIS_REGS; i++) begin
                h_act[i] <= h_pend[i];
                v_act[i] <= v_pend[i];
            end
            h_cur   <= cur_pend;
            ctl_il  <= il_pend;
            ctl_cs  <= cs_pend;
            ctl_dot <= dot_pend;
        end
    end

endmodule

// File: rtl/rtg_axis.sv
module rtg_axis
    import rtg_pkg::*;
#(
    parameter int VAL_W     = 10,
    parameter int CYCLE_ADD = 2,
    parameter int CNT_W     = VAL_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [VAL_W-1:0] cyc,
    input  logic [VAL_W-1:0] sync_w,
    input  logic [VAL_W-1:0] bord_start,
    input  logic [VAL_W-1:0] disp_start,
    input  logic [VAL_W-1:0] disp_end,
    input  logic [VAL_W-1:0] bord_end,
    output logic [CNT_W-1:0] cnt,
    output logic             last,
    output logic             in_sync,
    output logic             in_border,
    output logic             in_active
);

    seg_e             seg, seg_nx;
    logic [CNT_W-1:0] cnt_nx;

    function automatic logic [CNT_W-1:0] plus_one(input logic [VAL_W-1:0] v);
        return CNT_W'(v) + CNT_W'(1);
    endfunction

    // next count and next segment (count 0 always classifies as sync)
    always_comb begin
        last   = (cnt == CNT_W'(cyc) + CNT_W'(CYCLE_ADD - 1));
        cnt_nx = last ? '0 : cnt + CNT_W'(1);
        if (cnt_nx < plus_one(sync_w)) begin
            seg_nx = SEG_SYNC;
        end else if (cnt_nx < plus_one(bord_start)) begin
            seg_nx = SEG_LEAD_BLANK;
        end else if (cnt_nx < plus_one(disp_start)) begin
            seg_nx = SEG_LEAD_BORDER;
        end else if (cnt_nx < plus_one(disp_end)) begin
            seg_nx = SEG_ACTIVE;
        end else if (cnt_nx < plus_one(bord_end)) begin
            seg_nx = SEG_TRAIL_BORDER;
        end else begin
            seg_nx = SEG_TRAIL_BLANK;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            seg <= SEG_SYNC;
        end else if (step) begin
            cnt <= cnt_nx;
            seg <= seg_nx;
        end
    end

    // outputs
    always_comb begin
        in_sync   = 1'b0;
        in_border = 1'b0;
        in_active = 1'b0;
        unique case (seg)
            SEG_SYNC:         in_sync   = 1'b1;
            SEG_LEAD_BLANK:   ;
            SEG_LEAD_BORDER:  in_border = 1'b1;
            SEG_ACTIVE: begin
                in_border = 1'b1;
                in_active = 1'b1;
            end
            SEG_TRAIL_BORDER: in_border = 1'b1;
            SEG_TRAIL_BLANK:  ;
            default:          ;
        endcase
    end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int VAL_W      = 10,
    parameter int CURSOR_PIX = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        hires_cursor,
    output logic        hsync,
    output logic        vsync,
    output logic        sync_out,
    output logic        border_active,
    output logic        display_active,
    output logic        cursor_window,
    output logic        field_odd,
    output logic [1:0]  dot_sel
);

    localparam int CNT_W = VAL_W + 1;
    localparam int CUR_W = VAL_W + 3;
    localparam int PIX_W = CUR_W + 1;

    logic [VAL_W-1:0] h_act [NUM_AXIS_REGS];
    logic [VAL_W-1:0] v_act [NUM_AXIS_REGS];
    logic [CUR_W-1:0] h_cur;
    logic             ctl_il, ctl_cs;
    logic [1:0]       ctl_dot;

    logic [CNT_W-1:0] hcnt, vcnt;
    logic             h_last, v_last, frame_end;
    logic             h_sync, h_bord, h_disp;
    logic             v_sync, v_bord, v_disp;

    logic             shift_reached, v_first, v_after;
    logic [PIX_W-1:0] pix_pos, cur_lo, cur_hi;
    logic             h_cur_in, v_cur_in;

    assign frame_end = h_last & v_last;

    rtg_regs #(.VAL_W(VAL_W), .CUR_W(CUR_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .hires_cursor (hires_cursor),
        .frame_end    (frame_end),
        .h_act        (h_act),
        .v_act        (v_act),
        .h_cur        (h_cur),
        .ctl_il       (ctl_il),
        .ctl_cs       (ctl_cs),
        .ctl_dot      (ctl_dot)
    );

    rtg_axis #(.VAL_W(VAL_W), .CYCLE_ADD(2), .CNT_W(CNT_W)) u_h_axis (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (1'b1),
        .cyc        (h_act[IDX_CYCLE]),
        .sync_w     (h_act[IDX_SYNC_W]),
        .bord_start (h_act[IDX_BORD_START]),
        .disp_start (h_act[IDX_DISP_START]),
        .disp_end   (h_act[IDX_DISP_END]),
        .bord_end   (h_act[IDX_BORD_END]),
        .cnt        (hcnt),
        .last       (h_last),
        .in_sync    (h_sync),
        .in_border  (h_bord),
        .in_active  (h_disp)
    );

    rtg_axis #(.VAL_W(VAL_W), .CYCLE_ADD(1), .CNT_W(CNT_W)) u_v_axis (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (h_last),
        .cyc        (v_act[IDX_CYCLE]),
        .sync_w     (v_act[IDX_SYNC_W]),
        .bord_start (v_act[IDX_BORD_START]),
        .disp_start (v_act[IDX_DISP_START]),
        .disp_end   (v_act[IDX_DISP_END]),
        .bord_end   (v_act[IDX_BORD_END]),
        .cnt        (vcnt),
        .last       (v_last),
        .in_sync    (v_sync),
        .in_border  (v_bord),
        .in_active  (v_disp)
    );

    // field parity, updated at the frame boundary with the working control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_odd <= 1'b0;
        end else if (frame_end) begin
            field_odd <= ctl_il ? ~field_odd : 1'b0;
        end
    end

    // odd-field vertical sync shifted along the line
    always_comb begin
        shift_reached = hcnt >= CNT_W'(h_act[IDX_H_SHIFT]);
        v_first       = (vcnt == '0);
        v_after       = (vcnt == CNT_W'(v_act[IDX_SYNC_W]) + CNT_W'(1));
        if (field_odd) begin
            vsync = (v_sync && !(v_first && !shift_reached)) ||
                    (v_after && !shift_reached);
        end else begin
            vsync = v_sync;
        end
    end

    // cursor window: horizontal in pixels, vertical in lines
    always_comb begin
        pix_pos  = PIX_W'({hcnt, 1'b0});
        cur_lo   = PIX_W'(h_cur);
        cur_hi   = cur_lo + PIX_W'(CURSOR_PIX);
        h_cur_in = (pix_pos >= cur_lo) && (pix_pos < cur_hi);
        v_cur_in = (vcnt >= CNT_W'(v_act[IDX_CUR_START]) + CNT_W'(1)) &&
                   (vcnt <  CNT_W'(v_act[IDX_V_CUR_END]) + CNT_W'(1));
    end

    always_comb begin
        hsync          = h_sync;
        sync_out       = ctl_cs ? (h_sync ^ vsync) : h_sync;
        border_active  = h_bord & v_bord;
        display_active = h_disp & v_disp;
        cursor_window  = h_cur_in & v_cur_in;
        dot_sel        = ctl_dot;
    end

endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
    parameter int VAL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hsync,
    input logic             field_odd,
    input logic             border_active,
    input logic             display_active,
    input logic             frame_end,
    input logic [VAL_W:0]   hcnt,
    input logic [VAL_W:0]   vcnt,
    input logic [VAL_W-1:0] h_cycle,
    input logic [VAL_W-1:0] h_sync_w,
    input logic [VAL_W-1:0] v_cycle
);

    localparam int CW = VAL_W + 1;

    assert_hcnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hcnt <= CW'(h_cycle) + CW'(1));

    assert_vcnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vcnt <= CW'(v_cycle));

    assert_hsync_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync) |-> (hcnt == '0));

    assert_display_in_border_R5: assert property (@(posedge clk) disable iff (!rst_n)
        display_active |-> border_active);

    assert_field_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field_odd) |-> $past(frame_end));

    assert_hold_until_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> ($stable(h_cycle) && $stable(h_sync_w) && $stable(v_cycle)));

endmodule

bind raster_timing_gen rtg_checker #(.VAL_W(VAL_W)) u_rtg_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .hsync          (hsync),
    .field_odd      (field_odd),
    .border_active  (border_active),
    .display_active (display_active),
    .frame_end      (frame_end),
    .hcnt           (hcnt),
    .vcnt           (vcnt),
    .h_cycle        (h_act[0]),
    .h_sync_w       (h_act[1]),
    .v_cycle        (v_act[0])
);

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        hires_cursor;
    logic        hsync, vsync, sync_out, border_active, display_active;
    logic        cursor_window, field_odd;
    logic [1:0]  dot_sel;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    raster_timing_gen u_raster_timing_gen (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .hires_cursor   (hires_cursor),
        .hsync          (hsync),
        .vsync          (vsync),
        .sync_out       (sync_out),
        .border_active  (border_active),
        .display_active (display_active),
        .cursor_window  (cursor_window),
        .field_odd      (field_odd),
        .dot_sel        (dot_sel)
    );

    // columns: 0 hc 1 hsw 2 hbs 3 hds 4 hde 5 hbe 6 hcur 7 hshift
    //          8 vc 9 vsw 10 vbs 11 vds 12 vde 13 vbe 14 vcs 15 vce
    //          16 interlace 17 composite 18 hires 19 dot
    localparam int NCFG = 3;
    localparam int CFG [NCFG][20] = '{
        '{10, 1, 2, 3, 7, 8, 8, 5,  7, 0, 1, 2, 5, 6, 3, 4,  0, 0, 0, 1},
        '{13, 2, 3, 5,10,11, 6, 7,  9, 1, 2, 3, 7, 8, 2, 6,  1, 1, 1, 3},
        '{ 6, 0, 1, 2, 4, 5, 0, 2,  4, 0, 1, 2, 3, 4, 0, 3,  0, 1, 0, 2}
    };
    localparam int CUR_PIX = 32;

    int cur [20];
    int mh, mv, mf;
    int prev_len;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic check_all(input string ctx);
        int hs, vs, bd, dp, cw, so;
        hs = (mh < cur[1] + 1) ? 1 : 0;
        if (mf != 0)
            vs = (((mv < cur[9] + 1) && !(mv == 0 && mh < cur[7])) ||
                  (mv == cur[9] + 1 && mh < cur[7])) ? 1 : 0;
        else
            vs = (mv < cur[9] + 1) ? 1 : 0;
        bd = (mh >= cur[2] + 1 && mh < cur[5] + 1 && mv >= cur[10] + 1 && mv < cur[13] + 1) ? 1 : 0;
        dp = (mh >= cur[3] + 1 && mh < cur[4] + 1 && mv >= cur[11] + 1 && mv < cur[12] + 1) ? 1 : 0;
        cw = (2 * mh >= cur[6] && 2 * mh < cur[6] + CUR_PIX &&
              mv >= cur[14] + 1 && mv < cur[15] + 1) ? 1 : 0;
        so = (cur[17] != 0) ? (hs ^ vs) : hs;
        chk(hsync == hs,          {ctx, " R2 R3 hsync"},      int'(hsync), hs);
        chk(vsync == vs,          {ctx, " R3 R8 vsync"},      int'(vsync), vs);
        chk(border_active == bd,  {ctx, " R4 border"},        int'(border_active), bd);
        chk(display_active == dp, {ctx, " R5 display"},       int'(display_active), dp);
        chk(cursor_window == cw,  {ctx, " R6 cursor"},        int'(cursor_window), cw);
        chk(sync_out == so,       {ctx, " R7 sync_out"},      int'(sync_out), so);
        chk(field_odd == mf,      {ctx, " R8 field"},         int'(field_odd), mf);
        chk(dot_sel == cur[19],   {ctx, " R10 dot_sel"},      int'(dot_sel), cur[19]);
    endtask

    task automatic step_model();
        if (mh == cur[0] + 1) begin
            mh = 0;
            if (mv == cur[8]) begin
                mv = 0;
                mf = (cur[16] != 0) ? 1 - mf : 0;
            end else begin
                mv++;
            end
        end else begin
            mh++;
        end
    endtask

    task automatic run(input int n, input string ctx);
        for (int i = 0; i < n; i++) begin
            check_all(ctx);
            @(negedge clk);
            step_model();
        end
    endtask

    task automatic run_to_frame(input string ctx);
        do run(1, ctx); while (!(mh == 0 && mv == 0));
    endtask

    function automatic logic [31:0] word(input int tag, input int val, input int lsb);
        return (32'(tag) << 26) | (32'(val) << lsb);
    endfunction

    task automatic put(input logic [31:0] w);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic load_cfg(input int idx);
        bit found;
        bit prev_vs;
        hires_cursor = CFG[idx][18] != 0;
        for (int k = 0; k < 8; k++) begin
            if (k == 6)
                put(word(32'h20 + k, CFG[idx][k], (CFG[idx][18] != 0) ? 11 : 13));
            else
                put(word(32'h20 + k, CFG[idx][k], 14));
            put(word(32'h28 + k, CFG[idx][8 + k], 14));
        end
        put(word(32'h38, CFG[idx][19] | (CFG[idx][16] << 6) | (CFG[idx][17] << 7), 0));
        for (int c = 0; c < 20; c++) cur[c] = CFG[idx][c];
        repeat (2 * prev_len + 4) @(negedge clk);
        prev_len = (cur[0] + 2) * (cur[8] + 1);
        found   = 0;
        prev_vs = vsync;
        for (int i = 0; i < 4000 && !found; i++) begin
            @(negedge clk);
            if (vsync && !prev_vs && !field_odd) found = 1;
            prev_vs = vsync;
        end
        chk(found, "R9 new frame start seen", int'(found), 1);
        mh = 0; mv = 0; mf = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        n_checks++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        rst_n        = 1'b0;
        wr_en        = 1'b0;
        wr_data      = '0;
        hires_cursor = 1'b0;
        for (int c = 0; c < 20; c++) cur[c] = 0;
        mh = 0; mv = 0; mf = 0;
        prev_len = 2;

        // R11: state while reset is held and just after release
        repeat (3) @(negedge clk);
        check_all("R11 in reset");
        rst_n = 1'b1;
        run(6, "R11 after reset");

        // table of geometries, two frames each
        for (int t = 0; t < NCFG; t++) begin
            load_cfg(t);
            run_to_frame($sformatf("R2 table %0d frame a", t));
            run_to_frame($sformatf("R2 table %0d frame b", t));
        end

        // R9: writes in mid-frame wait for the frame boundary
        load_cfg(0);
        run(30, "R9 before write");
        wr_en = 1'b1; wr_data = word(32'h20, 12, 14);
        run(1, "R9 write cycle");
        wr_data = word(32'h21, 0, 14);
        run(1, "R9 write cycle");
        wr_data = word(32'h38, 1 | (1 << 7), 0);
        run(1, "R9 write cycle");
        wr_en = 1'b0; wr_data = '0;
        run_to_frame("R9 old geometry kept");
        cur[0] = 12; cur[1] = 0; cur[17] = 1;
        prev_len = (cur[0] + 2) * (cur[8] + 1);
        run_to_frame("R9 new geometry");

        // R1: unknown tag and strobe low leave everything unchanged
        run(5, "R1 before ignored writes");
        wr_en = 1'b1; wr_data = 32'hC3FF_FFFF;
        run(1, "R1 unknown tag");
        wr_data = 32'hF000_0000 | 32'h0003_C0C3;
        run(1, "R1 unknown tag");
        wr_en = 1'b0; wr_data = word(32'h20, 3, 14);
        run(1, "R1 strobe low");
        wr_data = word(32'h38, 2, 0);
        run(1, "R1 strobe low");
        wr_data = '0;
        run_to_frame("R1 ignored writes");
        run_to_frame("R1 ignored writes next frame");
        run_to_frame("R1 ignored writes third frame");

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule